// File: doc/BRIEF.md
# Security Code Verification Guard

This block decides whether write access to a protected store may be granted. It keeps a small security store of four bytes: byte 0 carries a three-bit retry counter in its low bits, and bytes 1 to 3 carry a three-byte reference code. A host presents already-decoded commands, each with a control byte, an address byte and a data byte. The three commands are a security read, a security update and a compare of one verification byte. On each command the block returns one response: a data byte and a fail flag. It also drives a level output that says whether the session is unlocked.

A host unlocks the session in three steps. First it burns one counter bit from 1 to 0 with an update of byte 0. It then compares code bytes 1, 2 and 3, in that order. If all three compares match, the session unlocks. The host may then restore the counter to all ones and rewrite the reference code. When the counter reaches zero, the block refuses every update and compare for good. A session reset ends an unlocked session and drops any partial progress. The stored counter and code stay as they are. A separate storage-initialise input models the first programming of the nonvolatile contents: counter all ones, code from a parameter.

Top module: `sec_guard`

## Requirements
- R1: Every command (cmd_valid high for one cycle) yields exactly one response with resp_valid high on the following cycle. A security read (control byte 0x31) of address 0 returns the counter zero-extended in bits 2..0 with fail low, whether locked or unlocked.
- R2: A security read of address 1, 2 or 3 returns 0x00 while locked and the stored reference byte while unlocked, with fail low.
- R3: While locked, an update (control byte 0x39) of address 0 can only clear counter bits. Data that would set a counter bit that is now 0 gives fail and leaves the counter unchanged. Data that clears one or more bits stores counter AND data, gives no fail and arms a new compare sequence.
- R4: A compare (control byte 0x33) made while no counter bit has been burned since the last sequence began gives fail and does not unlock.
- R5: After a burn, matching compares of addresses 1, 2 and 3, in that order, set unlocked on the cycle after the third compare. unlocked stays low after the first two.
- R6: A compare that mismatches, or arrives out of address order, gives fail and drops all progress and the arming. A later compare that would otherwise be correct then fails until a new bit is burned.
- R7: While the counter is 000, every update and every compare gives fail, and the block never unlocks.
- R8: While unlocked, an update of address 0 stores the low three data bits as the counter, ones included, and an update of address 1..3 stores the data as that code byte.
- R9: A session reset (rst_n low) clears unlocked, the progress and the arming, but keeps the counter and the code. A storage initialise (store_init_n low) also loads the counter with 111 and the code with INIT_CODE, where byte k is INIT_CODE bits 8k-1..8k-8.
- R10: An unknown control byte gives fail with no state change. An address with any bit above bit 1 set reads as 0x00 without fail, and makes an update or compare fail.
- R11: While locked, an update of address 1, 2 or 3 gives fail and leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low session reset, released synchronously inside |
| store_init_n | input | 1 | Asynchronous active-low initialise of counter and code (also resets the session) |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 8 | Control byte: 0x31 read, 0x39 update, 0x33 compare |
| cmd_addr | input | ADDR_W | Security byte address (0 counter, 1..3 code) |
| cmd_data | input | DATA_W | Write data or verification byte |
| resp_valid | output | 1 | Response strobe, one cycle after cmd_valid |
| resp_data | output | DATA_W | Read data (0x00 for non-read commands) |
| resp_fail | output | 1 | Command refused or compare failed |
| unlocked | output | 1 | Session unlocked |

## Verification
Every response appears exactly one clock after its command is sampled, because only the response register stands between the decision logic and the ports. The counter, the code bytes and unlocked change on that same edge. The bench drives each command on a falling edge and checks resp_valid, resp_data, resp_fail and unlocked on the next falling edge against its own model of the store. The next command can therefore be issued back-to-back. After either reset is released, the two-stage synchroniser needs two edges, so the bench waits several cycles before it checks the idle state or sends a command.

// File: rtl/sec_guard_pkg.sv
package sec_guard_pkg;
  localparam logic [7:0] OP_READ    = 8'h31;
  localparam logic [7:0] OP_UPDATE  = 8'h39;
  localparam logic [7:0] OP_COMPARE = 8'h33;

  typedef enum logic [1:0] {
    K_BAD     = 2'd0,
    K_READ    = 2'd1,
    K_UPDATE  = 2'd2,
    K_COMPARE = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/sec_rst_sync.sv
module sec_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/sec_cmd_decode.sv
module sec_cmd_decode
  import sec_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic [7:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output cmd_kind_e         kind,
  output logic [SEL_W-1:0]  sel,
  output logic              addr_ok
);
  always_comb begin
    unique case (op)
      OP_READ:    kind = K_READ;
      OP_UPDATE:  kind = K_UPDATE;
      OP_COMPARE: kind = K_COMPARE;
      default:    kind = K_BAD;
    endcase
  end

  assign sel     = addr[SEL_W-1:0];
  assign addr_ok = (addr[ADDR_W-1:SEL_W] == '0);
endmodule

// File: rtl/sec_store.sv
module sec_store #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  parameter int NCODE  = 3,
  parameter int SEL_W  = 2,
  parameter logic [NCODE*DATA_W-1:0] INIT_CODE = '0
) (
  input  logic                    clk,
  input  logic                    init_n,
  input  logic                    unlocked,
  input  logic                    cnt_we,
  input  logic [CNT_W-1:0]        cnt_wdata,
  input  logic                    code_we,
  input  logic [SEL_W-1:0]        code_sel,
  input  logic [DATA_W-1:0]       code_wdata,
  output logic [CNT_W-1:0]        cnt_q,
  output logic [NCODE*DATA_W-1:0] code_flat
);
  logic [NCODE-1:0][DATA_W-1:0] code_q;

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n)     cnt_q <= '1;
    else if (cnt_we) cnt_q <= cnt_wdata;
  end

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    always_ff @(posedge clk or negedge init_n) begin
      if (!init_n)
        code_q[g] <= INIT_CODE[g*DATA_W +: DATA_W];
      else if (code_we && (code_sel == SEL_W'(g + 1)))
        code_q[g] <= code_wdata;
    end
  end

  assign code_flat = code_q;

  // R3: while locked, no counter bit ever goes from 0 to 1
  p_locked_clear_only_r3: assert property (@(posedge clk) disable iff (!init_n)
    !unlocked |=> ((cnt_q & ~$past(cnt_q)) == '0));

  // R11: while locked, the reference code holds its value
  p_locked_code_stable_r11: assert property (@(posedge clk) disable iff (!init_n)
    !unlocked |=> $stable(code_flat));
endmodule

// File: rtl/sec_verify.sv
module sec_verify
  import sec_guard_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  parameter int NCODE  = 3,
  parameter int SEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  cmd_kind_e               kind,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    addr_ok,
  input  logic [DATA_W-1:0]       data,
  input  logic [CNT_W-1:0]        cnt_q,
  input  logic [NCODE*DATA_W-1:0] code_flat,
  output logic                    cnt_we,
  output logic [CNT_W-1:0]        cnt_wdata,
  output logic                    code_we,
  output logic [DATA_W-1:0]       code_wdata,
  output logic                    fail_d,
  output logic [DATA_W-1:0]       rdata_d,
  output logic                    unlocked
);
  localparam logic [SEL_W-1:0] LAST_STEP = SEL_W'(NCODE - 1);

  logic             unl_q, unl_d;
  logic             arm_q, arm_d;
  logic [SEL_W-1:0] prog_q, prog_d;
  logic [DATA_W-1:0] sel_ref;
  logic [CNT_W-1:0]  cnt_clr;
  logic              blocked;
  logic              cmp_ok;

  always_comb begin
    sel_ref = '0;
    for (int i = 0; i < NCODE; i++) begin
      if (sel == SEL_W'(i + 1)) sel_ref = code_flat[i*DATA_W +: DATA_W];
    end
  end

  assign blocked = (cnt_q == '0);
  assign cnt_clr = cnt_q & data[CNT_W-1:0];
  assign cmp_ok  = !blocked && arm_q && addr_ok &&
                   (sel == SEL_W'(prog_q + 1'b1)) && (data == sel_ref);

  always_comb begin
    unl_d      = unl_q;
    arm_d      = arm_q;
    prog_d     = prog_q;
    cnt_we     = 1'b0;
    cnt_wdata  = cnt_q;
    code_we    = 1'b0;
    code_wdata = data;
    fail_d     = 1'b0;
    rdata_d    = '0;
    if (cmd_valid) begin
      unique case (kind)
        K_READ: begin
          if (addr_ok) begin
            if (sel == '0)  rdata_d = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
            else if (unl_q) rdata_d = sel_ref;
          end
        end
        K_UPDATE: begin
          if (blocked || !addr_ok) begin
            fail_d = 1'b1;
          end else if (sel == '0) begin
            if (unl_q) begin
              cnt_we    = 1'b1;
              cnt_wdata = data[CNT_W-1:0];
            end else if ((data[CNT_W-1:0] & ~cnt_q) != '0) begin
              fail_d = 1'b1;
            end else if (cnt_clr != cnt_q) begin
              cnt_we    = 1'b1;
              cnt_wdata = cnt_clr;
              arm_d     = (cnt_clr != '0);
              prog_d    = '0;
            end
          end else if (unl_q) begin
            code_we = 1'b1;
          end else begin
            fail_d = 1'b1;
          end
        end
        K_COMPARE: begin
          if (!unl_q) begin
            if (!cmp_ok) begin
              fail_d = 1'b1;
              arm_d  = 1'b0;
              prog_d = '0;
            end else if (prog_q == LAST_STEP) begin
              unl_d  = 1'b1;
              arm_d  = 1'b0;
              prog_d = '0;
            end else begin
              prog_d = prog_q + 1'b1;
            end
          end
        end
        default: fail_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q  <= 1'b0;
      arm_q  <= 1'b0;
      prog_q <= '0;
    end else begin
      unl_q  <= unl_d;
      arm_q  <= arm_d;
      prog_q <= prog_d;
    end
  end

  assign unlocked = unl_q;

  // R5/R4: an unlock is always preceded by an armed sequence
  p_unlock_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(arm_q));

  // R7: an exhausted counter never lets the session open
  p_blocked_stays_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !unl_q) |=> !unl_q);

  // R4: a compare with nothing armed must be refused
  p_unarmed_compare_fails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && kind == K_COMPARE && !arm_q && !unl_q) |-> fail_d);
endmodule

// File: rtl/sec_guard.sv
module sec_guard
  import sec_guard_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 3,
  parameter int NCODE  = 3,
  parameter logic [NCODE*DATA_W-1:0] INIT_CODE = 24'hC35A17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_init_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_fail,
  output logic              unlocked
);
  localparam int SEL_W = $clog2(NCODE + 1);

  logic sess_srst_n, init_srst_n, sess_rst_n;
  cmd_kind_e kind;
  logic [SEL_W-1:0] sel;
  logic addr_ok;
  logic [CNT_W-1:0] cnt_q, cnt_wdata;
  logic [NCODE*DATA_W-1:0] code_flat;
  logic cnt_we, code_we, fail_d;
  logic [DATA_W-1:0] code_wdata, rdata_d;

  sec_rst_sync u_sync_sess (.clk(clk), .arst_n(rst_n),        .srst_n(sess_srst_n));
  sec_rst_sync u_sync_init (.clk(clk), .arst_n(store_init_n), .srst_n(init_srst_n));
  assign sess_rst_n = sess_srst_n & init_srst_n;

  sec_cmd_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
    .op(cmd_op), .addr(cmd_addr), .kind(kind), .sel(sel), .addr_ok(addr_ok)
  );

  sec_store #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NCODE(NCODE), .SEL_W(SEL_W), .INIT_CODE(INIT_CODE)
  ) u_store (
    .clk(clk), .init_n(init_srst_n), .unlocked(unlocked),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .code_we(code_we), .code_sel(sel), .code_wdata(code_wdata),
    .cnt_q(cnt_q), .code_flat(code_flat)
  );

  sec_verify #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NCODE(NCODE), .SEL_W(SEL_W)) u_ver (
    .clk(clk), .rst_n(sess_rst_n), .cmd_valid(cmd_valid), .kind(kind), .sel(sel),
    .addr_ok(addr_ok), .data(cmd_data), .cnt_q(cnt_q), .code_flat(code_flat),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .code_we(code_we), .code_wdata(code_wdata),
    .fail_d(fail_d), .rdata_d(rdata_d), .unlocked(unlocked)
  );

  always_ff @(posedge clk or negedge sess_rst_n) begin
    if (!sess_rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_fail  <= 1'b0;
    end else begin
      resp_valid <= cmd_valid;
      if (cmd_valid) begin
        resp_data <= rdata_d;
        resp_fail <= fail_d;
      end
    end
  end

  // R1: one response, exactly one cycle after each command
  p_resp_follows_cmd_r1: assert property (@(posedge clk) disable iff (!sess_rst_n || !init_srst_n)
    cmd_valid |=> resp_valid);
  p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!sess_rst_n || !init_srst_n)
    !cmd_valid |=> !resp_valid);
endmodule

// File: tb/tb_sec_guard.sv
`timescale 1ns/1ps
module tb_sec_guard;
  localparam logic [23:0] CODE0 = 24'hC35A17;

  logic clk = 1'b0;
  logic rst_n, store_init_n, cmd_valid;
  logic [7:0] cmd_op, cmd_addr, cmd_data, resp_data;
  logic resp_valid, resp_fail, unlocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] m_cnt;
  logic [7:0] m_code [3];
  logic       m_unl, m_arm;
  logic [1:0] m_prog;

  always #10 clk = ~clk;

  sec_guard dut (
    .clk(clk), .rst_n(rst_n), .store_init_n(store_init_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .resp_valid(resp_valid),
    .resp_data(resp_data), .resp_fail(resp_fail), .unlocked(unlocked)
  );

  function automatic logic [7:0] ref_byte(logic [1:0] s);
    return (s == 2'd0) ? 8'h00 : m_code[s-1];
  endfunction

  task automatic model_cmd(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d,
                           output logic [7:0] ed, output logic ef);
    logic aok = (a[7:2] == 6'd0);
    logic [1:0] s = a[1:0];
    logic blk = (m_cnt == 3'd0);
    ed = 8'h00; ef = 1'b0;
    if (op == 8'h31) begin
      if (aok) ed = (s == 0) ? {5'd0, m_cnt} : (m_unl ? ref_byte(s) : 8'h00);
    end else if (op == 8'h39) begin
      if (blk || !aok) ef = 1'b1;
      else if (s == 0) begin
        if (m_unl) m_cnt = d[2:0];
        else if ((d[2:0] & ~m_cnt) != 0) ef = 1'b1;
        else if ((m_cnt & d[2:0]) != m_cnt) begin
          m_cnt  = m_cnt & d[2:0];
          m_arm  = (m_cnt != 0);
          m_prog = 0;
        end
      end else if (m_unl) m_code[s-1] = d;
      else ef = 1'b1;
    end else if (op == 8'h33) begin
      if (!m_unl) begin
        if (blk || !m_arm || !aok || s != m_prog + 2'd1 || d != ref_byte(s)) begin
          ef = 1'b1; m_arm = 0; m_prog = 0;
        end else if (m_prog == 2) begin
          m_unl = 1; m_arm = 0; m_prog = 0;
        end else m_prog = m_prog + 1;
      end
    end else ef = 1'b1;
  endtask

  task automatic do_cmd(input string tag, input logic [7:0] op, input logic [7:0] a,
                        input logic [7:0] d);
    logic [7:0] ed; logic ef;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    model_cmd(op, a, d, ed, ef);
    @(negedge clk);
    cmd_valid = 1'b0;
    checks++;
    if (resp_valid !== 1'b1 || resp_data !== ed || resp_fail !== ef || unlocked !== m_unl) begin
      errors++;
      $display("FAIL %s op=%02h addr=%02h data=%02h: got v=%b d=%02h f=%b u=%b expected v=1 d=%02h f=%b u=%b",
               tag, op, a, d, resp_valid, resp_data, resp_fail, unlocked, ed, ef, m_unl);
    end
  endtask

  task automatic apply_reset(input bit with_init);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_init) store_init_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; store_init_n = 1'b1;
    m_unl = 0; m_arm = 0; m_prog = 0;
    if (with_init) begin
      m_cnt = 3'b111;
      for (int i = 0; i < 3; i++) m_code[i] = CODE0[i*8 +: 8];
    end
    repeat (4) @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || unlocked !== 1'b0 || resp_fail !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset state: got v=%b u=%b f=%b expected v=0 u=0 f=0",
               resp_valid, unlocked, resp_fail);
    end
  endtask

  task automatic unlock_seq(input string tag);
    do_cmd(tag, 8'h33, 8'd1, m_code[0]);
    do_cmd(tag, 8'h33, 8'd2, m_code[1]);
    do_cmd(tag, 8'h33, 8'd3, m_code[2]);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; store_init_n = 1'b0; cmd_valid = 1'b0;
    cmd_op = 8'h00; cmd_addr = 8'h00; cmd_data = 8'h00;
    apply_reset(1);

    do_cmd("R1 read counter", 8'h31, 8'd0, 8'h00);
    do_cmd("R2 locked code read", 8'h31, 8'd1, 8'h00);
    do_cmd("R4 unarmed compare", 8'h33, 8'd1, 8'h17);
    do_cmd("R3 burn bit", 8'h39, 8'd0, 8'h06);
    do_cmd("R1 counter after burn", 8'h31, 8'd0, 8'h00);
    do_cmd("R3 set bit refused", 8'h39, 8'd0, 8'h07);
    do_cmd("R3 counter kept", 8'h31, 8'd0, 8'h00);
    do_cmd("R11 locked code write", 8'h39, 8'd2, 8'h00);
    do_cmd("R6 first ok", 8'h33, 8'd1, 8'h17);
    do_cmd("R6 out of order", 8'h33, 8'd3, 8'hC3);
    do_cmd("R6 progress lost", 8'h33, 8'd2, 8'h5A);
    do_cmd("R3 burn again", 8'h39, 8'd0, 8'h04);
    do_cmd("R5 step1", 8'h33, 8'd1, 8'h17);
    do_cmd("R5 step2", 8'h33, 8'd2, 8'h5A);
    do_cmd("R5 step3", 8'h33, 8'd3, 8'hC3);
    do_cmd("R2 unlocked read", 8'h31, 8'd2, 8'h00);
    do_cmd("R8 restore counter", 8'h39, 8'd0, 8'h07);
    do_cmd("R8 counter read", 8'h31, 8'd0, 8'h00);
    do_cmd("R8 code write", 8'h39, 8'd1, 8'h99);
    do_cmd("R8 code read", 8'h31, 8'd1, 8'h00);
    apply_reset(0);
    do_cmd("R9 counter kept", 8'h31, 8'd0, 8'h00);
    do_cmd("R9 code hidden", 8'h31, 8'd1, 8'h00);
    do_cmd("R9 burn", 8'h39, 8'd0, 8'h06);
    unlock_seq("R9 new code unlocks");
    do_cmd("R9 new code read", 8'h31, 8'd1, 8'h00);
    do_cmd("R10 bad opcode", 8'h30, 8'd0, 8'h00);
    do_cmd("R10 bad read addr", 8'h31, 8'h41, 8'h00);
    do_cmd("R10 bad update addr", 8'h39, 8'h10, 8'h00);
    apply_reset(1);
    do_cmd("R7 burn", 8'h39, 8'd0, 8'h03);
    do_cmd("R7 burn", 8'h39, 8'd0, 8'h01);
    do_cmd("R7 burn last", 8'h39, 8'd0, 8'h00);
    do_cmd("R7 blocked compare", 8'h33, 8'd1, 8'h17);
    do_cmd("R7 blocked update", 8'h39, 8'd0, 8'h00);
    do_cmd("R7 counter zero", 8'h31, 8'd0, 8'h00);

    for (int n = 0; n < 400; n++) begin
      int unsigned r = $urandom % 10;
      logic [7:0] a = 8'($urandom % 4);
      if (n % 40 == 0) apply_reset(1);
      else if (n % 57 == 0) apply_reset(0);
      case (r)
        0, 1: do_cmd("RND read", 8'h31, ($urandom % 8 == 0) ? 8'h84 : a, 8'h00);
        2, 3: do_cmd("RND burn", 8'h39, 8'd0,
                     ($urandom % 4 == 0) ? 8'($urandom) : {5'd0, m_cnt & ~(3'd1 << ($urandom % 3))});
        4, 5, 6: begin
          logic [1:0] s = (m_prog == 2'd3) ? 2'd1 : m_prog + 2'd1;
          do_cmd("RND compare", 8'h33, {6'd0, s},
                 ($urandom % 10 == 0) ? 8'($urandom) : m_code[s-1]);
        end
        7: do_cmd("RND update", 8'h39, a, 8'($urandom));
        8: do_cmd("RND any", 8'($urandom), a, 8'($urandom));
        default: do_cmd("RND compare any", 8'h33, a, 8'($urandom));
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule